// File: doc/BRIEF.md
# Scan Chain Integrity Checker

This block tests whether a scan chain of known length is stitched end to end. It is started by a one-cycle request. It then raises the chain's shift enable and feeds a fixed serial test pattern into the chain input, one bit per clock. While doing so it watches the chain output. The chain adds a delay equal to its stage count, so each output bit is compared against the pattern bit sent that many clocks earlier.

When the run ends, the block reports a single pass flag, the index of the first pattern bit that came back wrong, and a saturating count of wrong bits. It never issues functional capture cycles. Its only diagnosis is the position of the first mismatch.

The verification environment includes a parameterized chain model. One of its stages can be replaced by a plain flop that has no scan path, which models a broken chain.

Top module: `chain_integrity_ctl`

## Requirements
- R1: While reset is low, and after it, until the first start: busy, done, pass and chain_shift_en are 0, chain_din is 0, and miss_count and fail_index are 0.
- R2: A start accepted while idle raises busy and chain_shift_en for exactly CHAIN_LEN+PAT_LEN cycles, beginning with the cycle after the start edge. In the cycle after the last one, busy and chain_shift_en are 0 and done is 1. Done is 1 for that single cycle only.
- R3: In run cycle k (counted from 0), chain_din carries pattern bit k for k < PAT_LEN. Pattern bit 0 is 1, and bit k for k >= 1 follows the repeating group 0,0,1,1, so bit k is 1 exactly when k mod 4 is 0 or 3. In the remaining run cycles chain_din is 0.
- R4: The chain output is compared only in run cycles CHAIN_LEN to CHAIN_LEN+PAT_LEN-1. Cycle c is checked against pattern bit c-CHAIN_LEN. Values seen in earlier run cycles have no effect on the results. Any sample that is not the expected known value counts as a mismatch, including X and Z.
- R5: miss_count counts mismatches in the current run and stops at 2^CNT_W-1.
- R6: fail_index holds the pattern index of the first mismatch of the run, or 0 if there was none. It does not change for later mismatches and is held until the next accepted start.
- R7: pass is cleared when a start is accepted. It becomes 1 with done only if the run saw no mismatch, and it is held until the next accepted start.
- R8: A start request while busy is high is ignored, and the run in progress keeps its timing.
- R9: In the chain model with shift enable high, each intact stage loads the previous stage (stage 0 loads the chain input), so a bit reaches the output CHAIN_LEN clocks after it is applied. With shift enable low, each stage loads its functional input.
- R10: A chain model stage chosen as broken always loads its functional input. Against such a chain with constant functional data, the checker reports fail. Against the intact chain, it reports pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Test request, sampled on the clock edge |
| busy | output | 1 | A test run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Last run saw no mismatch |
| fail_index | output | $clog2(PAT_LEN) | Pattern index of the first mismatch |
| miss_count | output | CNT_W | Saturating mismatch count |
| chain_din | output | 1 | Serial data into the chain |
| chain_shift_en | output | 1 | Shift enable for the chain |
| chain_dout | input | 1 | Serial data from the chain output |

## Verification
The embedded assertions check the following on every cycle:
- done is a single pulse that follows the fall of busy;
- a run advances one step per clock, whatever happens on start;
- the mismatch count holds at its ceiling;
- the first-fail index freezes once a mismatch has been seen;
- the pass flag agrees with the mismatch count when done is high.

Only the bench scenarios can show these:
- the serial pattern values;
- the alignment of the comparison window with the chain delay;
- that output values before the window are disregarded;
- that an intact chain passes and a chain with a non-scan stage fails with the expected first index and saturated count.

// File: rtl/scanchk_pkg.sv
package scanchk_pkg;

   // Width of a counter that must hold values 0..n-1 (at least 1 bit).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/chk_pattern_gen.sv
// Test pattern source.
// Bit 0 is 1. After that the group 0,0,1,1 repeats.
// With that shape, a stuck-at-0, a stuck-at-1 or a one-place shift always mismatches.
module chk_pattern_gen #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] idx,
   output logic         bit_o
);
   logic [W-1:0] prev;

   always_comb begin
      prev  = idx - W'(1);
      bit_o = (idx == '0) ? 1'b1 : prev[W > 1 ? 1 : 0];
   end

   generate
      if (W < 2) begin : g_bad_w
         $error("chk_pattern_gen: W must be at least 2");
      end
   endgenerate
endmodule

// File: rtl/chk_sequencer.sv
// Run control: accepts start, counts the run steps, produces the done pulse.
module chk_sequencer #(
   parameter int unsigned CHAIN_LEN = 8,
   parameter int unsigned PAT_LEN   = 16,
   parameter int unsigned STEP_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [STEP_W-1:0] step,
   output logic              launch,
   output logic              finish,
   output logic              cmp_en
);
   localparam int unsigned TOTAL = CHAIN_LEN + PAT_LEN;
   localparam logic [STEP_W-1:0] LAST  = STEP_W'(TOTAL - 1);
   localparam logic [STEP_W-1:0] FIRST = STEP_W'(CHAIN_LEN);

   assign launch = start & ~busy;
   assign finish = busy & (step == LAST);
   assign cmp_en = busy & (step >= FIRST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         step <= '0;
      end else begin
         done <= finish;
         if (launch) begin
            busy <= 1'b1;
            step <= '0;
         end else if (finish) begin
            busy <= 1'b0;
            step <= '0;
         end else if (busy) begin
            step <= step + STEP_W'(1);
         end
      end
   end

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step != LAST) |=> (busy && step == $past(step) + STEP_W'(1)));
endmodule

// File: rtl/chk_compare.sv
// Mismatch bookkeeping: saturating count plus the first failing pattern index.
module chk_compare #(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cmp_en,
   input  logic [IDX_W-1:0] cmp_idx,
   input  logic             observed,
   input  logic             expected,
   output logic             miss_now,
   output logic             any_miss,
   output logic [IDX_W-1:0] first_idx,
   output logic [CNT_W-1:0] miss_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R4: a 4-state inequality, so X or Z on the chain counts as a miss.
   assign miss_now = cmp_en & (observed !== expected);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any_miss  <= 1'b0;
         first_idx <= '0;
         miss_cnt  <= '0;
      end else if (clr) begin
         any_miss  <= 1'b0;
         first_idx <= '0;
         miss_cnt  <= '0;
      end else if (miss_now) begin
         any_miss <= 1'b1;
         if (!any_miss) first_idx <= cmp_idx;
         if (miss_cnt != CNT_MAX) miss_cnt <= miss_cnt + CNT_W'(1);
      end
   end

   // R5
   count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && miss_cnt == CNT_MAX) |=> (miss_cnt == CNT_MAX));

   // R6
   first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && any_miss) |=> $stable(first_idx));
endmodule

// File: rtl/chain_integrity_ctl.sv
module chain_integrity_ctl
   import scanchk_pkg::*;
#(
   parameter  int unsigned CHAIN_LEN = 8,
   parameter  int unsigned PAT_LEN   = 16,
   parameter  int unsigned CNT_W     = 8,
   localparam int unsigned IDX_W     = idx_width(PAT_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             pass,
   output logic [IDX_W-1:0] fail_index,
   output logic [CNT_W-1:0] miss_count,
   output logic             chain_din,
   output logic             chain_shift_en,
   input  logic             chain_dout
);
   localparam int unsigned TOTAL  = CHAIN_LEN + PAT_LEN;
   localparam int unsigned STEP_W = idx_width(TOTAL) + 1;

   generate
      if (CHAIN_LEN < 1) begin : g_bad_chain
         $error("chain_integrity_ctl: CHAIN_LEN must be at least 1");
      end
      if (PAT_LEN < 2) begin : g_bad_pat
         $error("chain_integrity_ctl: PAT_LEN must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("chain_integrity_ctl: CNT_W must be at least 1");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic [STEP_W-1:0] rel_step;
   logic              launch, finish, cmp_en;
   logic              drive_bit, exp_bit;
   logic              miss_now, any_miss;
   logic              pass_q;

   chk_sequencer #(
      .CHAIN_LEN(CHAIN_LEN), .PAT_LEN(PAT_LEN), .STEP_W(STEP_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .step(step), .launch(launch), .finish(finish), .cmp_en(cmp_en)
   );

   chk_pattern_gen #(.W(STEP_W)) u_pat_drive (.idx(step), .bit_o(drive_bit));

   assign rel_step = step - STEP_W'(CHAIN_LEN);

   chk_pattern_gen #(.W(STEP_W)) u_pat_expect (.idx(rel_step), .bit_o(exp_bit));

   assign chain_shift_en = busy;
   assign chain_din      = busy & (step < STEP_W'(PAT_LEN)) & drive_bit;

   chk_compare #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(launch), .cmp_en(cmp_en),
      .cmp_idx(rel_step[IDX_W-1:0]), .observed(chain_dout), .expected(exp_bit),
      .miss_now(miss_now), .any_miss(any_miss), .first_idx(fail_index),
      .miss_cnt(miss_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pass_q <= 1'b0;
      else if (launch) pass_q <= 1'b0;
      else if (finish) pass_q <= ~(any_miss | miss_now);
   end
   assign pass = pass_q;

   // R7
   done_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass == (miss_count == '0)));

   // R7
   pass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pass);
endmodule

// File: tb/scan_chain_model.sv
// Chain model. A stage whose index equals BREAK_AT has no scan path.
// BREAK_AT = -1 gives an intact chain.
module scan_chain_model #(
   parameter int STAGES   = 8,
   parameter int BREAK_AT = -1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              ser_in,
   input  logic [STAGES-1:0] func_in,
   output logic              ser_out
);
   logic [STAGES-1:0] q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic prev, st;
      if (i == 0) begin : g_head
         assign prev = ser_in;
      end else begin : g_link
         assign prev = q[i-1];
      end
      if (i == BREAK_AT) begin : g_plain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= 1'b0;
            else        st <= func_in[i];
      end else begin : g_scan
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= 1'b0;
            else        st <= shift_en ? prev : func_in[i];
      end
      assign q[i] = st;
   end

   assign ser_out = q[STAGES-1];
endmodule

// File: tb/chain_integrity_ctl_bench.sv
module chain_integrity_ctl_bench;
   localparam int N   = 8;
   localparam int L   = 16;
   localparam int TOT = N + L;
   localparam int BRK = 3;

   // Columns: [15] broken chain, [14] functional data, [13] pass,
   // [12:8] first index, [7:0] mismatch count.
   localparam logic [15:0] VEC [4] = '{16'h2000, 16'h6000, 16'h8007, 16'hC107};

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, start_a, start_b;
   logic [N-1:0] func;
   logic busy_a, done_a, pass_a, din_a, se_a, dout_a;
   logic busy_b, done_b, pass_b, din_b, se_b, dout_b;
   logic [3:0] idx_a, idx_b;
   logic [7:0] cnt_a;
   logic [2:0] cnt_b;

   chain_integrity_ctl #(.CHAIN_LEN(N), .PAT_LEN(L), .CNT_W(8)) u_chain_integrity_ctl (
      .clk(clk), .rst_n(rst_n), .start(start_a), .busy(busy_a), .done(done_a),
      .pass(pass_a), .fail_index(idx_a), .miss_count(cnt_a), .chain_din(din_a),
      .chain_shift_en(se_a), .chain_dout(dout_a));

   scan_chain_model #(.STAGES(N), .BREAK_AT(-1)) u_chain_ok (
      .clk(clk), .rst_n(rst_n), .shift_en(se_a), .ser_in(din_a),
      .func_in(func), .ser_out(dout_a));

   chain_integrity_ctl #(.CHAIN_LEN(N), .PAT_LEN(L), .CNT_W(3)) u_chain_integrity_ctl_brk (
      .clk(clk), .rst_n(rst_n), .start(start_b), .busy(busy_b), .done(done_b),
      .pass(pass_b), .fail_index(idx_b), .miss_count(cnt_b), .chain_din(din_b),
      .chain_shift_en(se_b), .chain_dout(dout_b));

   scan_chain_model #(.STAGES(N), .BREAK_AT(BRK)) u_chain_bad (
      .clk(clk), .rst_n(rst_n), .shift_en(se_b), .ser_in(din_b),
      .func_in(func), .ser_out(dout_b));

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ref_bit(input int k);
      return ((k % 4 == 0) || (k % 4 == 3)) ? 1 : 0;
   endfunction

   task automatic run(input bit brk, input bit fv, input bit poke);
      func = {N{fv}};
      @(negedge clk);
      if (brk) start_b = 1'b1; else start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      start_b = 1'b0;
      for (int s = 0; s < TOT; s++) begin
         chk("R2 busy in run",  brk ? busy_b : busy_a, 1);
         chk("R2 shift enable", brk ? se_b : se_a, 1);
         chk("R2 no done",      brk ? done_b : done_a, 0);
         if (s == 0) chk("R7 pass cleared on start", brk ? pass_b : pass_a, 0);
         chk("R3 serial data", brk ? din_b : din_a, (s < L) ? ref_bit(s) : 0);
         if (poke) begin
            if (s == 3) begin
               if (brk) start_b = 1'b1; else start_a = 1'b1;
            end else begin
               start_a = 1'b0;
               start_b = 1'b0;
            end
         end
         @(negedge clk);
      end
      chk(poke ? "R8 done on time" : "R2 done pulse", brk ? done_b : done_a, 1);
      chk("R2 busy low", brk ? busy_b : busy_a, 0);
      chk("R2 shift enable low", brk ? se_b : se_a, 0);
   endtask

   task automatic end_done(input bit brk);
      @(negedge clk);
      chk("R2 done one cycle", brk ? done_b : done_a, 0);
      chk(poke_restart_msg(), brk ? busy_b : busy_a, 0);
   endtask

   function automatic string poke_restart_msg();
      return "R8 no restart";
   endfunction

   initial begin
      rst_n   = 1'b0;
      start_a = 1'b0;
      start_b = 1'b0;
      func    = '0;
      repeat (3) @(negedge clk);
      chk("R1 busy",  busy_a, 0);
      chk("R1 done",  done_a, 0);
      chk("R1 pass",  pass_a, 0);
      chk("R1 se",    se_a, 0);
      chk("R1 din",   din_a, 0);
      chk("R1 count", cnt_a, 0);
      chk("R1 index", idx_a, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", busy_a, 0);

      // R9: with shift enable low, stages load their functional inputs.
      func = '1;
      @(negedge clk);
      chk("R9 functional load", dout_a, 1);
      func = '0;
      @(negedge clk);
      chk("R9 functional load zero", dout_a, 0);

      foreach (VEC[i]) begin
         run(VEC[i][15], VEC[i][14], 1'b0);
         chk("R10 pass flag",   VEC[i][15] ? pass_b : pass_a, int'(VEC[i][13]));
         chk("R6 first index",  VEC[i][15] ? idx_b : idx_a,   int'(VEC[i][12:8]));
         chk("R5 R4 count",     VEC[i][15] ? cnt_b : cnt_a,   int'(VEC[i][7:0]));
         end_done(VEC[i][15]);
         chk("R7 pass held", VEC[i][15] ? pass_b : pass_a, int'(VEC[i][13]));
      end

      // R8: a start pulse in the middle of a run is ignored.
      run(1'b1, 1'b0, 1'b1);
      chk("R8 count", cnt_b, 7);
      chk("R8 index", idx_b, 0);
      end_done(1'b1);

      // R4: the intact chain passes with ones loaded before the window.
      run(1'b0, 1'b1, 1'b1);
      chk("R4 window ignores earlier output", pass_a, 1);
      chk("R4 count zero", cnt_a, 0);
      end_done(1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule